// File: doc/BRIEF.md
# Buffered Synthesizer Control Word Loader

This block sits in front of a numerically controlled oscillator and owns the word that steers it. Software or a host controller fills a hidden 40-bit staging register in one of two ways: five writes on a byte-wide port, or forty bits shifted in on a single data pin with its own load clock. None of this touches the oscillator. Only when a separate update strobe arrives does the whole staged word move into the live registers, so all of its fields change in one clock edge.

The live outputs are a 32-bit tuning word, a 5-bit phase offset, a power-down enable and a 2-bit format field. The staging register keeps the control byte in bits [7:0] and the tuning word in bits [39:8], and both load paths fill that same layout. The serial load clock is brought into the system clock domain through a synchroniser before its rising edges are detected. A status output records whether the word moved by the latest update had been loaded in full or was left part-way through a sequence.

Top module: `dds_ctrl_loader`

## Requirements
- R1: While reset is low, and after it is released, the staging register, the byte and bit counters, every live output and the status output are zero. An update issued straight after reset therefore drives zeros.
- R2: The first byte of a parallel sequence is the control byte. Its bits [7:3] become the phase offset, bit 2 becomes the power-down enable and bits [1:0] become the format field.
- R3: Parallel bytes two to five form the tuning word with the most significant byte first: byte two supplies tuning bits [31:24] and byte five supplies bits [7:0].
- R4: The byte counter runs 0 to 4 and wraps to 0 after the fifth write, so a sixth write overwrites the control byte.
- R5: Parallel writes and serial bits change only the staging register. The live outputs and the status output hold their values on every clock without an update strobe.
- R6: The clock edge that samples the update strobe high loads every live field from the staging register, and all of them change on that same edge.
- R7: The update strobe clears the byte counter, so the next parallel write lands in the control byte.
- R8: An update issued during an incomplete parallel sequence transfers the staging register as it stands: bytes not yet rewritten keep their earlier values. The status output then reads 0.
- R9: Each rising edge of the serial load clock, once synchronised, shifts the staging register one place toward bit 0 and puts the serial data bit into bit 39. After forty edges the first bit sent sits in bit 0, so the stream is sent least significant bit first: control byte bits 0 to 7, then tuning bits 0 to 31.
- R10: The update strobe clears the serial bit counter. An update issued after a number of serial bits that is not a multiple of forty sets the status output to 0.
- R11: An update issued when both counters are at zero sets the status output to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 8 | Byte for a parallel write |
| bus_wr | input | 1 | Parallel write strobe, one byte per cycle high |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial load clock, asynchronous to clk |
| freq_upd | input | 1 | Update strobe: moves the staged word to the live registers |
| tune_word | output | 32 | Live tuning word |
| phase_word | output | 5 | Live phase offset |
| power_down | output | 1 | Live power-down enable |
| load_fmt | output | 2 | Live format field |
| load_complete | output | 1 | High if the latest update moved a fully loaded word |

## Verification
The bench builds the block with its default parameters: eight-bit bytes, five bytes per word and a two-stage serial synchroniser. With these values the fifth-byte wrap, the fortieth-bit wrap and the layout shared by the serial and parallel paths are all exercised. The sequences include a six-byte overrun, a two-byte partial load, an update used to restart a sequence, a full forty-bit serial word, and an eight-bit partial serial load that leaves a shifted mix of old and new bits in the staging register.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;

   // Bit position of parallel byte k inside the staging register.
   // Byte 0 is the control byte at the bottom; bytes 1.. fill the
   // tuning word from its most significant byte downward.
   function automatic int byte_lsb(input int k, input int nbytes, input int bw);
      return (k == 0) ? 0 : bw * (nbytes - k);
   endfunction

   // Counter width that never collapses to zero bits.
   function automatic int cnt_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dds_ldr_sync.sv
module dds_ldr_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES == 1) begin : g_single
      logic [W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q <= '0;
         else        stg_q <= d;
      end
      assign q = stg_q;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg_q <= '0;
         else        stg_q <= {stg_q[STAGES-2:0], d};
      end
      assign q = stg_q[STAGES-1];
   end

endmodule

// File: rtl/dds_ldr_buffer.sv
module dds_ldr_buffer
   import dds_ldr_pkg::*;
#(
   parameter  int BYTE_W    = 8,
   parameter  int NUM_BYTES = 5,
   localparam int WORD_W    = BYTE_W * NUM_BYTES,
   localparam int PCNT_W    = cnt_w(NUM_BYTES),
   localparam int SCNT_W    = cnt_w(WORD_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic              ser_clk_s,
   input  logic              ser_bit_s,
   input  logic              clr,
   output logic [WORD_W-1:0] buf_word,
   output logic [PCNT_W-1:0] pcnt,
   output logic [SCNT_W-1:0] scnt,
   output logic              partial
);

   localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(NUM_BYTES - 1);
   localparam logic [SCNT_W-1:0] SCNT_LAST = SCNT_W'(WORD_W - 1);

   logic              sclk_q;
   logic              ser_rise;
   logic [WORD_W-1:0] buf_q;

   assign ser_rise = ser_clk_s & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q  <= '0;
         pcnt   <= '0;
         scnt   <= '0;
         sclk_q <= 1'b0;
      end else begin
         sclk_q <= ser_clk_s;
         // staging register: a parallel write wins over a serial shift
         if (wr) begin
            for (int k = 0; k < NUM_BYTES; k++) begin
               if (pcnt == PCNT_W'(k))
                  buf_q[byte_lsb(k, NUM_BYTES, BYTE_W) +: BYTE_W] <= wdata;
            end
         end else if (ser_rise) begin
            buf_q <= {ser_bit_s, buf_q[WORD_W-1:1]};
         end
         // counters
         if (clr) begin
            pcnt <= '0;
            scnt <= '0;
         end else begin
            if (wr)
               pcnt <= (pcnt == PCNT_LAST) ? '0 : pcnt + PCNT_W'(1);
            if (ser_rise && !wr)
               scnt <= (scnt == SCNT_LAST) ? '0 : scnt + SCNT_W'(1);
         end
      end
   end

   assign buf_word = buf_q;
   assign partial  = (pcnt != '0) || (scnt != '0);

endmodule

// File: rtl/dds_ldr_active.sv
module dds_ldr_active #(
   parameter  int BYTE_W    = 8,
   parameter  int NUM_BYTES = 5,
   parameter  int PHASE_W   = 5,
   parameter  int FMT_W     = 2,
   localparam int WORD_W    = BYTE_W * NUM_BYTES,
   localparam int TUNE_W    = WORD_W - BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd,
   input  logic [WORD_W-1:0]  buf_word,
   input  logic               partial,
   output logic [TUNE_W-1:0]  tune,
   output logic [PHASE_W-1:0] phase,
   output logic               pd,
   output logic [FMT_W-1:0]   fmt,
   output logic               complete
);

   logic [BYTE_W-1:0] ctrl_byte;
   assign ctrl_byte = buf_word[BYTE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tune     <= '0;
         phase    <= '0;
         pd       <= 1'b0;
         fmt      <= '0;
         complete <= 1'b0;
      end else if (upd) begin
         tune     <= buf_word[WORD_W-1:BYTE_W];
         phase    <= ctrl_byte[BYTE_W-1 -: PHASE_W];
         pd       <= ctrl_byte[FMT_W];
         fmt      <= ctrl_byte[FMT_W-1:0];
         complete <= ~partial;
      end
   end

endmodule

// File: rtl/dds_ctrl_loader.sv
module dds_ctrl_loader
   import dds_ldr_pkg::*;
#(
   parameter  int BYTE_W      = 8,
   parameter  int NUM_BYTES   = 5,
   parameter  int PHASE_W     = 5,
   parameter  int FMT_W       = 2,
   parameter  int SYNC_STAGES = 2,
   localparam int WORD_W      = BYTE_W * NUM_BYTES,
   localparam int TUNE_W      = WORD_W - BYTE_W,
   localparam int PCNT_W      = cnt_w(NUM_BYTES),
   localparam int SCNT_W      = cnt_w(WORD_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BYTE_W-1:0]  bus_data,
   input  logic               bus_wr,
   input  logic               ser_data,
   input  logic               ser_clk,
   input  logic               freq_upd,
   output logic [TUNE_W-1:0]  tune_word,
   output logic [PHASE_W-1:0] phase_word,
   output logic               power_down,
   output logic [FMT_W-1:0]   load_fmt,
   output logic               load_complete
);

   if (PHASE_W + 1 + FMT_W != BYTE_W) begin : g_bad_ctrl
      $error("control byte fields must fill exactly one byte");
   end
   if (NUM_BYTES < 2) begin : g_bad_bytes
      $error("need a control byte and at least one tuning byte");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("serial synchroniser needs at least one stage");
   end

   logic [1:0]        ser_s;
   logic [WORD_W-1:0] buf_word;
   logic [PCNT_W-1:0] pcnt;
   logic [SCNT_W-1:0] scnt;
   logic              partial;

   dds_ldr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_data}),
      .q     (ser_s)
   );

   dds_ldr_buffer #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (bus_wr),
      .wdata     (bus_data),
      .ser_clk_s (ser_s[1]),
      .ser_bit_s (ser_s[0]),
      .clr       (freq_upd),
      .buf_word  (buf_word),
      .pcnt      (pcnt),
      .scnt      (scnt),
      .partial   (partial)
   );

   dds_ldr_active #(
      .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PHASE_W(PHASE_W), .FMT_W(FMT_W)
   ) u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (freq_upd),
      .buf_word (buf_word),
      .partial  (partial),
      .tune     (tune_word),
      .phase    (phase_word),
      .pd       (power_down),
      .fmt      (load_fmt),
      .complete (load_complete)
   );

endmodule

// File: rtl/dds_ldr_checker.sv
module dds_ldr_checker #(
   parameter  int BYTE_W    = 8,
   parameter  int NUM_BYTES = 5,
   parameter  int PHASE_W   = 5,
   parameter  int FMT_W     = 2,
   parameter  int PCNT_W    = 3,
   parameter  int SCNT_W    = 6,
   localparam int WORD_W    = BYTE_W * NUM_BYTES,
   localparam int TUNE_W    = WORD_W - BYTE_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic               freq_upd,
   input logic [WORD_W-1:0]  buf_word,
   input logic [PCNT_W-1:0]  pcnt,
   input logic [SCNT_W-1:0]  scnt,
   input logic [TUNE_W-1:0]  tune_word,
   input logic [PHASE_W-1:0] phase_word,
   input logic               power_down,
   input logic [FMT_W-1:0]   load_fmt,
   input logic               load_complete
);

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_upd |=> $stable({tune_word, phase_word, power_down, load_fmt, load_complete}));

   assert_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      freq_upd |=> (tune_word == $past(buf_word[WORD_W-1:BYTE_W]))
                && (phase_word == $past(buf_word[BYTE_W-1 -: PHASE_W]))
                && (power_down == $past(buf_word[FMT_W]))
                && (load_fmt == $past(buf_word[FMT_W-1:0])));

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !freq_upd && pcnt == PCNT_W'(NUM_BYTES - 1)) |=> (pcnt == '0));

   assert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt < PCNT_W'(NUM_BYTES));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      freq_upd |=> (pcnt == '0) && (scnt == '0));

   assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
      freq_upd |=> load_complete == ($past(pcnt) == '0 && $past(scnt) == '0));

endmodule

bind dds_ctrl_loader dds_ldr_checker #(
   .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .PHASE_W(PHASE_W), .FMT_W(FMT_W),
   .PCNT_W(PCNT_W), .SCNT_W(SCNT_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .bus_wr        (bus_wr),
   .freq_upd      (freq_upd),
   .buf_word      (buf_word),
   .pcnt          (pcnt),
   .scnt          (scnt),
   .tune_word     (tune_word),
   .phase_word    (phase_word),
   .power_down    (power_down),
   .load_fmt      (load_fmt),
   .load_complete (load_complete)
);

// File: tb/dds_ctrl_loader_tb_top.sv
`timescale 1ns/1ps
module dds_ctrl_loader_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_data = '0;
   logic        bus_wr = 1'b0;
   logic        ser_data = 1'b0;
   logic        ser_clk = 1'b0;
   logic        freq_upd = 1'b0;
   logic [31:0] tune_word;
   logic [4:0]  phase_word;
   logic        power_down;
   logic [1:0]  load_fmt;
   logic        load_complete;

   always #10 clk = ~clk;   // 50 MHz

   dds_ctrl_loader dut_i (
      .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_wr(bus_wr),
      .ser_data(ser_data), .ser_clk(ser_clk), .freq_upd(freq_upd),
      .tune_word(tune_word), .phase_word(phase_word), .power_down(power_down),
      .load_fmt(load_fmt), .load_complete(load_complete)
   );

   // ---------------- behavioural reference model ----------------
   logic [39:0] m_buf;
   int          m_pcnt, m_scnt;
   logic        m_sclk_prev;
   logic [31:0] e_tune;
   logic [4:0]  e_phase;
   logic        e_pd, e_comp;
   logic [1:0]  e_fmt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_buf = '0; m_pcnt = 0; m_scnt = 0; m_sclk_prev = 1'b0;
         e_tune = '0; e_phase = '0; e_pd = 1'b0; e_fmt = '0; e_comp = 1'b0;
      end else begin
         if (freq_upd) begin
            e_tune  = m_buf[39:8];
            e_phase = m_buf[7:3];
            e_pd    = m_buf[2];
            e_fmt   = m_buf[1:0];
            e_comp  = (m_pcnt == 0) && (m_scnt == 0);
         end
         if (bus_wr) begin
            if (m_pcnt == 0) m_buf[7:0] = bus_data;
            else             m_buf[8*(5-m_pcnt) +: 8] = bus_data;
            m_pcnt = (m_pcnt + 1) % 5;
         end else if (ser_clk && !m_sclk_prev) begin
            m_buf  = {ser_data, m_buf[39:1]};
            m_scnt = (m_scnt + 1) % 40;
         end
         m_sclk_prev = ser_clk;
         if (freq_upd) begin m_pcnt = 0; m_scnt = 0; end
      end
   end

   // ---------------- every-clock comparison (R5 R6) ----------------
   int  c_total = 0, c_bad = 0;
   logic cmp_on = 1'b0;
   always @(negedge clk) begin
      if (cmp_on) begin
         c_total++;
         if ({tune_word, phase_word, power_down, load_fmt, load_complete} !==
             {e_tune, e_phase, e_pd, e_fmt, e_comp}) begin
            c_bad++;
            $display("FAIL R5 R6 per-clock model: got %h/%0d/%0b/%0d/%0b expected %h/%0d/%0b/%0d/%0b",
                     tune_word, phase_word, power_down, load_fmt, load_complete,
                     e_tune, e_phase, e_pd, e_fmt, e_comp);
         end
      end
   end

   // ---------------- directed checks ----------------
   int n_total = 0, n_bad = 0;

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_total++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic chk_out(input string req, input logic [31:0] t, input logic [4:0] p,
                          input logic d, input logic [1:0] f, input logic c);
      chk({req, " tune"},     64'(tune_word),     64'(t));
      chk({req, " phase"},    64'(phase_word),    64'(p));
      chk({req, " pd"},       64'(power_down),    64'(d));
      chk({req, " fmt"},      64'(load_fmt),      64'(f));
      chk({req, " complete"}, 64'(load_complete), 64'(c));
   endtask

   task automatic pwrite(input logic [7:0] b);
      @(negedge clk); bus_wr = 1'b1; bus_data = b;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic update();
      @(negedge clk); freq_upd = 1'b1;
      @(negedge clk); freq_upd = 1'b0;
   endtask

   task automatic sbit(input logic b);
      @(negedge clk); ser_data = b;
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin : watchdog
      #4_000_000;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", n_total + c_total + 1, n_bad + c_bad + 1);
      $finish;
   end

   initial begin : main
      logic [39:0] sw;
      repeat (3) @(negedge clk);
      chk_out("R1 in reset", 32'h0, 5'd0, 1'b0, 2'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      chk_out("R1 after reset", 32'h0, 5'd0, 1'b0, 2'd0, 1'b0);

      // full parallel load
      pwrite(8'hA6); pwrite(8'h12); pwrite(8'h34); pwrite(8'h56); pwrite(8'h78);
      chk_out("R5 staged not live", 32'h0, 5'd0, 1'b0, 2'd0, 1'b0);
      update();
      chk("R3 tune msb first", 64'(tune_word), 64'h12345678);
      chk("R2 phase field",   64'(phase_word), 64'd20);
      chk("R2 pd field",      64'(power_down), 64'd1);
      chk("R2 fmt field",     64'(load_fmt),   64'd2);
      chk("R11 complete",     64'(load_complete), 64'd1);

      // six writes: sixth overwrites control byte
      pwrite(8'h01); pwrite(8'h9A); pwrite(8'hBC); pwrite(8'hDE); pwrite(8'hF0);
      pwrite(8'h5B);
      chk("R5 hold during load", 64'(tune_word), 64'h12345678);
      update();
      chk_out("R4 wrap", 32'h9ABCDEF0, 5'd11, 1'b0, 2'd3, 1'b0);

      // partial parallel load after counter clear
      pwrite(8'h08); pwrite(8'hAA);
      update();
      chk_out("R8 partial", 32'hAABCDEF0, 5'd1, 1'b0, 2'd0, 1'b0);
      pwrite(8'hFF);
      update();
      chk_out("R7 restart at control", 32'hAABCDEF0, 5'd31, 1'b1, 2'd3, 1'b0);
      update();
      chk("R11 complete after clear", 64'(load_complete), 64'd1);

      // full serial word, least significant bit first
      sw = {32'hC3A50F1E, 8'h93};
      for (int i = 0; i < 40; i++) sbit(sw[i]);
      chk("R5 serial hold", 64'(tune_word), 64'hAABCDEF0);
      update();
      chk_out("R9 serial word", 32'hC3A50F1E, 5'd18, 1'b0, 2'd3, 1'b1);

      // partial serial: 8 bits of 0x2C
      for (int i = 0; i < 8; i++) sbit(1'(8'h2C >> i));
      update();
      chk_out("R10 partial serial", 32'h2CC3A50F, 5'd3, 1'b1, 2'd2, 1'b0);
      update();
      chk("R10 counter cleared", 64'(load_complete), 64'd1);

      // reset in mid-sequence clears staging and live state
      pwrite(8'h77); pwrite(8'h66);
      @(negedge clk); cmp_on = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      chk_out("R1 mid reset", 32'h0, 5'd0, 1'b0, 2'd0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk); cmp_on = 1'b1;
      update();
      chk_out("R1 staging cleared", 32'h0, 5'd0, 1'b0, 2'd0, 1'b1);

      repeat (4) @(negedge clk);
      cmp_on = 1'b0;
      $display("  test done: total=%0d bad=%0d", n_total + c_total, n_bad + c_bad);
      $finish;
   end

endmodule